// File: doc/BRIEF.md
# Audio PCM Slot Router for a Frame-Based Codec Link

This block sits between the frame framers of a codec link and the audio datapath. It works on parallel 20-bit slot words, once per frame. On the controller-to-codec side it takes the ten data slots 3..12 and their tag bits. From them it picks the left and right playback samples out of one of four selectable slot pairs. On the codec-to-controller side it builds the ten outgoing slot words and their tag bits. It places the stereo record samples into a selectable slot pair and forms the slot 12 audio interrupt word.

Each direction has a 2-bit pair selector. Both selectors use the same encoding. A one-cycle strobe marks each frame boundary. Everything the block produces is registered on that strobe and then held until the next one. Selector, data and control changes between strobes therefore only take effect at the next boundary. Serialisation and sample-rate conversion belong to other blocks.

Top module: `pcm_slot_router`

## Requirements
- R1: While reset is asserted, both playback outputs, all ten outgoing slot words and all ten outgoing tag bits are zero.
- R2: Slot pair selector encoding, the same for both directions: 0 selects slots 3 (left) and 4 (right), 1 selects 6 and 9, 2 selects 7 and 8, 3 selects 10 and 11. Slot s occupies bits [(s-3)*20 +: 20] of a slot vector, and bit s-3 of a tag vector. That tag bit stands for frame tag bit s. On a strobe, the playback left/right outputs load the words of the pair chosen by the playback selector.
- R3: A playback sample loads only when the tag bit of its own slot is 1 on the strobe. Otherwise that output keeps its previous value. Left and right are gated independently.
- R4: On a strobe with the record-valid input high, the record left/right samples go into the pair chosen by the record selector, and those two tag bits are set.
- R5: On a strobe with record-valid low, no record slot carries data. All of slots 3..11 are zero with their tags clear.
- R6: Every outgoing slot 3..11 that is not part of the chosen record pair is zero with its tag clear.
- R7: When the interrupt enable is 1 and no modem is present, the slot 12 word has bits 19..1 zero and bit 0 equal to the interrupt request sampled on the strobe, and the slot 12 tag is set.
- R8: When the interrupt enable is 0 or a modem is present, the slot 12 word is zero and its tag is clear.
- R9: All outputs change only in the cycle after a strobe. Input changes between strobes have no effect until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | One-cycle frame boundary strobe |
| dac_sel_i | input | 2 | Playback slot pair selector |
| dl_tag_i | input | 10 | Incoming tag bits for slots 3..12 |
| dl_slot_i | input | 200 | Incoming slot words 3..12, 20 bits each |
| dac_left_o | output | 20 | Playback left sample |
| dac_right_o | output | 20 | Playback right sample |
| adc_sel_i | input | 2 | Record slot pair selector |
| adc_valid_i | input | 1 | Record samples valid this frame |
| adc_left_i | input | 20 | Record left sample |
| adc_right_i | input | 20 | Record right sample |
| irq_req_i | input | 1 | Audio interrupt request |
| irq_en_i | input | 1 | Audio interrupt enable |
| modem_present_i | input | 1 | A modem codec shares the link |
| ul_tag_o | output | 10 | Outgoing tag bits for slots 3..12 |
| ul_slot_o | output | 200 | Outgoing slot words 3..12 |

## Verification
Every result is due exactly one clock after the edge that samples a strobe, because each output comes from a single register stage. Outputs must then stay fixed for as long as no strobe arrives. The bench updates its model on the same rising edge the design uses and compares all outputs shortly after every rising edge. Both late and early changes show up as mismatches. Between strobes the stimulus scrambles the selectors, data and tags so that any leak before the next boundary is exposed.

// File: rtl/pcm_router_pkg.sv
package pcm_router_pkg;
    localparam int SW         = 20;
    localparam int NSLOT      = 10;
    localparam int FIRST_SLOT = 3;
    localparam int AUD        = NSLOT - 1;

    typedef logic [SW-1:0] sample_t;
    typedef logic [1:0]    pair_sel_t;

    // slot index (slot number minus FIRST_SLOT) of one half of a pair
    function automatic int pair_idx(input pair_sel_t sel, input logic right);
        case (sel)
            2'd0:    return right ? 1 : 0;
            2'd1:    return right ? 6 : 3;
            2'd2:    return right ? 5 : 4;
            default: return right ? 8 : 7;
        endcase
    endfunction
endpackage

// File: rtl/pcm_dac_capture.sv
module pcm_dac_capture
    import pcm_router_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_i,
    input  pair_sel_t            sel_i,
    input  logic [NSLOT-1:0]     tag_i,
    input  logic [NSLOT*SW-1:0]  slot_i,
    output sample_t              left_o,
    output sample_t              right_o
);
    typedef struct packed {
        sample_t left;
        sample_t right;
    } st_t;

    st_t st_d, st_q;
    int  li, ri;

    always_comb begin
        st_d = st_q;
        li   = pair_idx(sel_i, 1'b0);
        ri   = pair_idx(sel_i, 1'b1);
        if (frame_i) begin
            if (tag_i[li]) st_d.left  = slot_i[li*SW +: SW];
            if (tag_i[ri]) st_d.right = slot_i[ri*SW +: SW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_o  = st_q.left;
    assign right_o = st_q.right;
endmodule

// File: rtl/pcm_adc_placer.sv
module pcm_adc_placer
    import pcm_router_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_i,
    input  pair_sel_t          sel_i,
    input  logic               valid_i,
    input  sample_t            left_i,
    input  sample_t            right_i,
    output logic [AUD-1:0]     tag_o,
    output logic [AUD*SW-1:0]  data_o
);
    typedef struct packed {
        logic [AUD-1:0]    tag;
        logic [AUD*SW-1:0] data;
    } st_t;

    st_t st_d, st_q;
    int  li, ri;

    always_comb begin
        st_d = st_q;
        li   = pair_idx(sel_i, 1'b0);
        ri   = pair_idx(sel_i, 1'b1);
        if (frame_i) begin
            st_d = '0;
            if (valid_i) begin
                st_d.tag[li]             = 1'b1;
                st_d.tag[ri]             = 1'b1;
                st_d.data[li*SW +: SW]   = left_i;
                st_d.data[ri*SW +: SW]   = right_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tag_o  = st_q.tag;
    assign data_o = st_q.data;
endmodule

// File: rtl/pcm_irq_slot.sv
module pcm_irq_slot
    import pcm_router_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    frame_i,
    input  logic    req_i,
    input  logic    en_i,
    input  logic    modem_i,
    output logic    tag_o,
    output sample_t word_o
);
    typedef struct packed {
        logic tag;
        logic irq;
    } st_t;

    st_t  st_d, st_q;
    logic usable;

    always_comb begin
        st_d   = st_q;
        usable = en_i && !modem_i;
        if (frame_i) begin
            st_d.tag = usable;
            st_d.irq = usable && req_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tag_o  = st_q.tag;
    assign word_o = {{(SW-1){1'b0}}, st_q.irq};
endmodule

// File: rtl/pcm_slot_router.sv
module pcm_slot_router
    import pcm_router_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_i,
    input  logic [1:0]           dac_sel_i,
    input  logic [NSLOT-1:0]     dl_tag_i,
    input  logic [NSLOT*SW-1:0]  dl_slot_i,
    output logic [SW-1:0]        dac_left_o,
    output logic [SW-1:0]        dac_right_o,
    input  logic [1:0]           adc_sel_i,
    input  logic                 adc_valid_i,
    input  logic [SW-1:0]        adc_left_i,
    input  logic [SW-1:0]        adc_right_i,
    input  logic                 irq_req_i,
    input  logic                 irq_en_i,
    input  logic                 modem_present_i,
    output logic [NSLOT-1:0]     ul_tag_o,
    output logic [NSLOT*SW-1:0]  ul_slot_o
);
    logic [AUD-1:0]    adc_tag;
    logic [AUD*SW-1:0] adc_data;
    logic              irq_tag;
    sample_t           irq_word;

    pcm_dac_capture u_dac (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (frame_i),
        .sel_i   (dac_sel_i),
        .tag_i   (dl_tag_i),
        .slot_i  (dl_slot_i),
        .left_o  (dac_left_o),
        .right_o (dac_right_o)
    );

    pcm_adc_placer u_adc (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (frame_i),
        .sel_i   (adc_sel_i),
        .valid_i (adc_valid_i),
        .left_i  (adc_left_i),
        .right_i (adc_right_i),
        .tag_o   (adc_tag),
        .data_o  (adc_data)
    );

    pcm_irq_slot u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_i (frame_i),
        .req_i   (irq_req_i),
        .en_i    (irq_en_i),
        .modem_i (modem_present_i),
        .tag_o   (irq_tag),
        .word_o  (irq_word)
    );

    assign ul_tag_o  = {irq_tag, adc_tag};
    assign ul_slot_o = {irq_word, adc_data};
endmodule

// File: rtl/pcm_slot_router_chk.sv
module pcm_slot_router_chk
    import pcm_router_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_i,
    input logic [1:0]           dac_sel_i,
    input logic [NSLOT-1:0]     dl_tag_i,
    input logic [NSLOT*SW-1:0]  dl_slot_i,
    input logic [SW-1:0]        dac_left_o,
    input logic [SW-1:0]        dac_right_o,
    input logic [1:0]           adc_sel_i,
    input logic                 adc_valid_i,
    input logic [SW-1:0]        adc_left_i,
    input logic [SW-1:0]        adc_right_i,
    input logic                 irq_req_i,
    input logic                 irq_en_i,
    input logic                 modem_present_i,
    input logic [NSLOT-1:0]     ul_tag_o,
    input logic [NSLOT*SW-1:0]  ul_slot_o
);
    for (genvar k = 0; k < NSLOT; k++) begin : g_idle
        AST_IDLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !ul_tag_o[k] |-> ul_slot_o[k*SW +: SW] == '0); // R6
    end

    AST_IRQ_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ul_slot_o[NSLOT*SW-1 -: SW-1] == '0); // R7

    AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && irq_en_i && !modem_present_i |=>
            ul_tag_o[NSLOT-1] && ul_slot_o[(NSLOT-1)*SW] == $past(irq_req_i)); // R7

    AST_IRQ_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && (modem_present_i || !irq_en_i) |=> !ul_tag_o[NSLOT-1]); // R8

    AST_ADC_PAIR_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ul_tag_o[AUD-1:0]) == 0 || $countones(ul_tag_o[AUD-1:0]) == 2); // R4

    AST_ADC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && !adc_valid_i |=> ul_tag_o[AUD-1:0] == '0); // R5

    AST_DAC_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && dac_sel_i == 2'd0 && !dl_tag_i[0] |=> $stable(dac_left_o)); // R3

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_i |=> $stable(dac_left_o) && $stable(dac_right_o)
                  && $stable(ul_tag_o) && $stable(ul_slot_o)); // R9
endmodule

bind pcm_slot_router pcm_slot_router_chk u_chk (.*);

// File: tb/pcm_slot_router_bench.sv
module pcm_slot_router_bench;
    import pcm_router_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                rst_n = 1'b0;
    logic                frame_i = 1'b0;
    logic [1:0]          dac_sel_i = '0, adc_sel_i = '0;
    logic [NSLOT-1:0]    dl_tag_i = '0;
    logic [NSLOT*SW-1:0] dl_slot_i = '0;
    logic [SW-1:0]       dac_left_o, dac_right_o;
    logic                adc_valid_i = 1'b0;
    logic [SW-1:0]       adc_left_i = '0, adc_right_i = '0;
    logic                irq_req_i = 1'b0, irq_en_i = 1'b0, modem_present_i = 1'b0;
    logic [NSLOT-1:0]    ul_tag_o;
    logic [NSLOT*SW-1:0] ul_slot_o;

    pcm_slot_router u_pcm_slot_router (.*);

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural reference: slot numbers of each pair
    int          lslot [4] = '{3, 6, 7, 10};
    int          rslot [4] = '{4, 9, 8, 11};
    logic [19:0] m_left, m_right;
    logic [19:0] m_word [3:12];
    bit          m_tag  [3:12];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_right = 0;
            for (int s = 3; s <= 12; s++) begin m_word[s] = 0; m_tag[s] = 0; end
        end else if (frame_i) begin
            int ls, rs;
            ls = lslot[dac_sel_i]; rs = rslot[dac_sel_i];
            if (dl_tag_i[ls-3]) m_left  = dl_slot_i[(ls-3)*20 +: 20];
            if (dl_tag_i[rs-3]) m_right = dl_slot_i[(rs-3)*20 +: 20];
            for (int s = 3; s <= 12; s++) begin m_word[s] = 0; m_tag[s] = 0; end
            if (adc_valid_i) begin
                m_word[lslot[adc_sel_i]] = adc_left_i;  m_tag[lslot[adc_sel_i]] = 1;
                m_word[rslot[adc_sel_i]] = adc_right_i; m_tag[rslot[adc_sel_i]] = 1;
            end
            if (irq_en_i && !modem_present_i) begin
                m_tag[12]  = 1;
                m_word[12] = {19'd0, irq_req_i};
            end
        end
    end

    task automatic cmp(input string req, input string what, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        if (!done) begin
            cmp(!rst_n ? "R1" : "R2/R3/R9", "dac_left",  dac_left_o,  m_left);
            cmp(!rst_n ? "R1" : "R2/R3/R9", "dac_right", dac_right_o, m_right);
            for (int s = 3; s <= 12; s++) begin
                string rq;
                rq = !rst_n ? "R1" : (s == 12 ? "R7/R8/R9" : "R4/R5/R6/R9");
                cmp(rq, $sformatf("tag slot %0d", s), 20'(ul_tag_o[s-3]), 20'(m_tag[s]));
                cmp(rq, $sformatf("word slot %0d", s), ul_slot_o[(s-3)*SW +: SW], m_word[s]);
            end
        end
    end

    task automatic scramble();
        dac_sel_i = 2'($urandom); adc_sel_i = 2'($urandom);
        dl_tag_i = 10'($urandom); adc_valid_i = 1'($urandom);
        adc_left_i = 20'($urandom); adc_right_i = 20'($urandom);
        irq_req_i = 1'($urandom); irq_en_i = 1'($urandom); modem_present_i = 1'($urandom);
        for (int k = 0; k < NSLOT; k++) dl_slot_i[k*SW +: SW] = 20'($urandom);
    endtask

    task automatic do_frame(input int ds, input int as, input logic [9:0] tg,
                            input bit av, input bit rq, input bit en, input bit md);
        @(negedge clk);
        scramble();
        dac_sel_i = 2'(ds); adc_sel_i = 2'(as); dl_tag_i = tg; adc_valid_i = av;
        irq_req_i = rq; irq_en_i = en; modem_present_i = md;
        frame_i = 1'b1;
        @(negedge clk);
        frame_i = 1'b0;
        scramble();   // R9: ignored until next strobe
        @(negedge clk);
        scramble();
    endtask

    initial begin
        repeat (3) @(negedge clk);   // R1 checked while in reset
        rst_n = 1'b1;
        for (int d = 0; d < 4; d++) do_frame(d, 0, 10'h3FF, 0, 0, 0, 0);   // R2
        do_frame(1, 0, 10'b0000001000, 0, 0, 0, 0);                         // R3 left only
        do_frame(2, 0, 10'b0000100000, 0, 0, 0, 0);                         // R3 right only
        do_frame(3, 0, 10'b0000000000, 0, 0, 0, 0);                         // R3 hold both
        for (int a = 0; a < 4; a++) do_frame(0, a, 10'h3FF, 1, 0, 0, 0);   // R4, R6
        do_frame(0, 2, 10'h3FF, 0, 0, 0, 0);                                // R5
        do_frame(0, 1, 10'h000, 1, 1, 1, 0);                                // R7 request 1
        do_frame(0, 1, 10'h000, 1, 0, 1, 0);                                // R7 request 0
        do_frame(0, 3, 10'h000, 1, 1, 1, 1);                                // R8 modem
        do_frame(0, 3, 10'h000, 1, 1, 0, 0);                                // R8 disabled
        for (int i = 0; i < 300; i++)
            do_frame(int'($urandom % 4), int'($urandom % 4), 10'($urandom),
                     1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule